// File: doc/BRIEF.md
# In-Place Right-Shift Address Generator for a Bit-Serial Register File

This block produces the bit and word addresses used by a bit-serial datapath whose words are 18 bit times long, so that an arithmetic right shift can be carried out in place in the register file. Each bit time is split into ticks of a fast clock. During the first half of the bit time (the read half) the address sent to the accumulator and product storage can be advanced by one bit. Bit i+1 is then read while bit i is the one written later in the same bit time. When the advanced bit number reaches 18 it folds to 0 and carries into the word address, which wraps at the last word. Advancing is held off in bit time 17 of a most-significant word, so that the sign bit is read back onto itself and the shift is arithmetic.

Writes are allowed only in the last quarter of each bit time, a full quarter after the read half ends. This keeps an address change from ever meeting an active write. The multiplier storage always sees the address exactly as presented. Three one-bit-wide behavioural arrays (accumulator, multiplier, product) sit behind the address logic. Each has one registered read port and one write port, and the external serial datapath reads, processes and writes one bit per bit time.

Top module: `rsh_addr_gen`

## Requirements
- R1: While reset is high, rd_phase, wr_win, acc_we, mul_we, prd_we, ab_bit, ab_word, mr_bit and mr_word are all 0.
- R2: After reset, each bit time lasts TICKS clock cycles (default 4). rd_phase is high in the first two cycles and low in the last two. wr_win is high only in the fourth cycle, and the pattern repeats.
- R3: The outputs show the values of bit_no and word_addr that were present at the clock edge opening the current cycle. Outside the read half, and throughout whenever rsh_en is 0, ab_bit and ab_word equal those values.
- R4: In the read half with rsh_en at 1 and bit_no from 0 to 16, ab_bit is bit_no+1 and ab_word equals word_addr. This also holds when msw is 1.
- R5: In the read half with rsh_en at 1, msw at 0 and bit_no at 17, ab_bit is 0 and ab_word is word_addr+1. From the last word (WORDS-1) ab_word wraps to 0.
- R6: In the read half with rsh_en at 1, msw at 1 and bit_no at 17, ab_bit is 17 and ab_word equals word_addr.
- R7: mr_bit and mr_word always equal the presented bit_no and word_addr, and the multiplier array is accessed only at that address. A shift with rsh_en at 1 that writes the multiplier therefore leaves its contents unchanged.
- R8: wsel encodes 0 none, 1 accumulator, 2 multiplier, 3 product. wsel and wr_data are sampled at the edge opening the fourth cycle, and the selected strobe is high only in that cycle. At most one strobe is high at a time.
- R9: A strobe stores wr_data at the address of its array in that cycle. acc_rd, mul_rd and prd_rd show, one cycle later, the bit stored at the address the array saw in the cycle before.
- R10: For 36 bit times, with rsh_en at 1 and the read bit fed back as write data, the first 18 bit times are on word w with msw at 0 and the next 18 are on word w+1 (mod WORDS) with msw at 1. The pair then holds its former 36-bit two's-complement value shifted right arithmetically by one place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock, TICKS cycles per bit time |
| rst | input | 1 | Synchronous active-high reset |
| bit_no | input | BN_W (5) | Current bit number, 0 to 17 |
| word_addr | input | WA_W (2) | Register word address |
| rsh_en | input | 1 | Enables the one-bit address advance in the read half |
| msw | input | 1 | The current word is the most significant one |
| wsel | input | 2 | Write target: 0 none, 1 accumulator, 2 multiplier, 3 product |
| wr_data | input | 1 | Bit to be written in this bit time |
| ab_bit | output | BN_W (5) | Effective bit address for accumulator and product |
| ab_word | output | WA_W (2) | Effective word address for accumulator and product |
| mr_bit | output | BN_W (5) | Bit address for the multiplier (never advanced) |
| mr_word | output | WA_W (2) | Word address for the multiplier |
| rd_phase | output | 1 | High in the read half of the bit time |
| wr_win | output | 1 | High in the last quarter of the bit time |
| acc_we | output | 1 | Gated accumulator write strobe |
| mul_we | output | 1 | Gated multiplier write strobe |
| prd_we | output | 1 | Gated product write strobe |
| acc_rd | output | 1 | Accumulator read bit |
| mul_rd | output | 1 | Multiplier read bit |
| prd_rd | output | 1 | Product read bit |

## Verification
The bench exercises the fold from bit 17 into the next word, including the wrap from the last word to word 0. A design that forgot the carry would read the low word's own bit 0 and corrupt the shifted pair. It also hits bit 17 of a most-significant word, where a design that still advanced would shift in the next word's bit instead of copying the sign, so a negative value would turn positive. Shifting the multiplier catches a design that advanced that array's address too, because its contents would move. The strobes and addresses are checked in every tick of every bit time: a strobe that leaked into the read half, or an advance that lingered outside it, would write the wrong bit.

// File: rtl/rsh_pkg.sv
package rsh_pkg;

  // Storage arrays behind the address generator
  localparam int REG_ACC = 0;
  localparam int REG_MUL = 1;
  localparam int REG_PRD = 2;
  localparam int NREG    = 3;

  // Write target codes; each array index maps to code index+1
  typedef enum logic [1:0] {
    WS_NONE = 2'd0,
    WS_ACC  = 2'd1,
    WS_MUL  = 2'd2,
    WS_PRD  = 2'd3
  } wsel_e;

  function automatic logic [1:0] ws_code(input int idx);
    return 2'(idx + 1);
  endfunction

endpackage

// File: rtl/rsh_phase_gen.sv
module rsh_phase_gen #(
  parameter int TICKS = 4,
  localparam int PH_W = (TICKS > 1) ? $clog2(TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  output logic rd_next,
  output logic win_next
);

  localparam logic [PH_W-1:0] PH_LAST = PH_W'(TICKS - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(TICKS / 2);
  localparam logic [PH_W-1:0] PH_WIN  = PH_W'(TICKS - TICKS / 4);

  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] ph_next;

  // Tick position that the coming clock edge will enter
  always_comb begin
    ph_next = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
  end

  // Reset parks on the last tick so the first bit time opens cleanly
  always_ff @(posedge clk) begin
    if (rst) ph_q <= PH_LAST;
    else     ph_q <= ph_next;
  end

  assign rd_next  = (ph_next < PH_HALF);
  assign win_next = (ph_next >= PH_WIN);

endmodule

// File: rtl/rsh_addr_inc.sv
module rsh_addr_inc #(
  parameter int BITS  = 18,
  parameter int WORDS = 4,
  parameter int BN_W  = 5,
  parameter int WA_W  = 2
) (
  input  logic [BN_W-1:0] bit_in,
  input  logic [WA_W-1:0] word_in,
  input  logic            inc_on,
  output logic [BN_W-1:0] bit_out,
  output logic [WA_W-1:0] word_out
);

  localparam logic [BN_W:0]   SUM_LIM   = (BN_W+1)'(BITS);
  localparam logic [BN_W-1:0] BIT_LIM   = BN_W'(BITS);
  localparam logic [WA_W-1:0] WORD_LAST = WA_W'(WORDS - 1);

  logic [BN_W:0]   sum;
  logic            fold;
  logic [WA_W-1:0] word_up;

  assign sum  = {1'b0, bit_in} + 1'b1;
  assign fold = (sum == SUM_LIM);

  // Word carry: free wrap for a power-of-two word count, compare otherwise
  generate
    if (WORDS == (1 << WA_W)) begin : g_wrap_free
      assign word_up = word_in + 1'b1;
    end else begin : g_wrap_cmp
      assign word_up = (word_in == WORD_LAST) ? '0 : word_in + 1'b1;
    end
  endgenerate

  always_comb begin
    if (!inc_on) begin
      bit_out  = bit_in;
      word_out = word_in;
    end else if (fold) begin
      bit_out  = '0;
      word_out = word_up;
    end else begin
      bit_out  = sum[BN_W-1:0];
      word_out = word_in;
    end
  end

  // R4
  always_comb begin
    if (bit_in < BIT_LIM) begin
      bit_range_chk: assert (bit_out < BIT_LIM);
    end
  end

endmodule

// File: rtl/rsh_bit_ram.sv
module rsh_bit_ram #(
  parameter int DEPTH = 72,
  parameter int AD_W  = 7
) (
  input  logic            clk,
  input  logic            we,
  input  logic [AD_W-1:0] addr,
  input  logic            din,
  output logic            dout
);

  logic mem [DEPTH];

  // Single-port, read-before-write, registered read
  always_ff @(posedge clk) begin
    if (we) mem[addr] <= din;
    dout <= mem[addr];
  end

endmodule

// File: rtl/rsh_addr_gen.sv
module rsh_addr_gen
  import rsh_pkg::*;
#(
  parameter int BITS  = 18,
  parameter int WORDS = 4,
  parameter int TICKS = 4,
  localparam int BN_W  = $clog2(BITS),
  localparam int WA_W  = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int DEPTH = WORDS * BITS,
  localparam int AD_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BN_W-1:0] bit_no,
  input  logic [WA_W-1:0] word_addr,
  input  logic            rsh_en,
  input  logic            msw,
  input  logic [1:0]      wsel,
  input  logic            wr_data,
  output logic [BN_W-1:0] ab_bit,
  output logic [WA_W-1:0] ab_word,
  output logic [BN_W-1:0] mr_bit,
  output logic [WA_W-1:0] mr_word,
  output logic            rd_phase,
  output logic            wr_win,
  output logic            acc_we,
  output logic            mul_we,
  output logic            prd_we,
  output logic            acc_rd,
  output logic            mul_rd,
  output logic            prd_rd
);

  localparam logic [BN_W-1:0] BIT_TOP   = BN_W'(BITS - 1);
  localparam logic [WA_W-1:0] WORD_LAST = WA_W'(WORDS - 1);

  function automatic logic [AD_W-1:0] flat(input logic [WA_W-1:0] w,
                                           input logic [BN_W-1:0] b);
    return AD_W'(w) * AD_W'(BITS) + AD_W'(b);
  endfunction

  // ---------------- tick timing ----------------
  logic rd_next;
  logic win_next;

  rsh_phase_gen #(.TICKS(TICKS)) u_phase (
    .clk      (clk),
    .rst      (rst),
    .rd_next  (rd_next),
    .win_next (win_next)
  );

  // ---------------- address advance ----------------
  logic            inc_on;
  logic [BN_W-1:0] inc_bit;
  logic [WA_W-1:0] inc_word;

  // Advance only in the read half, and never on the sign bit of the top word
  assign inc_on = rd_next && rsh_en && !(msw && (bit_no == BIT_TOP));

  rsh_addr_inc #(
    .BITS  (BITS),
    .WORDS (WORDS),
    .BN_W  (BN_W),
    .WA_W  (WA_W)
  ) u_inc (
    .bit_in   (bit_no),
    .word_in  (word_addr),
    .inc_on   (inc_on),
    .bit_out  (inc_bit),
    .word_out (inc_word)
  );

  // ---------------- registered outputs ----------------
  logic [BN_W-1:0] ab_bit_q, mr_bit_q;
  logic [WA_W-1:0] ab_word_q, mr_word_q;
  logic            rd_q, win_q, wd_q;
  logic [NREG-1:0] we_q;
  logic [NREG-1:0] rd_bits;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_bit_q  <= '0;
      ab_word_q <= '0;
      mr_bit_q  <= '0;
      mr_word_q <= '0;
      rd_q      <= 1'b0;
      win_q     <= 1'b0;
      wd_q      <= 1'b0;
      we_q      <= '0;
    end else begin
      ab_bit_q  <= inc_bit;
      ab_word_q <= inc_word;
      mr_bit_q  <= bit_no;
      mr_word_q <= word_addr;
      rd_q      <= rd_next;
      win_q     <= win_next;
      wd_q      <= wr_data;
      for (int i = 0; i < NREG; i++) begin
        we_q[i] <= win_next && (wsel == ws_code(i));
      end
    end
  end

  // ---------------- storage arrays ----------------
  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      logic [AD_W-1:0] addr;
      if (g == REG_MUL) begin : g_plain
        assign addr = flat(mr_word_q, mr_bit_q);
      end else begin : g_shifted
        assign addr = flat(ab_word_q, ab_bit_q);
      end
      rsh_bit_ram #(.DEPTH(DEPTH), .AD_W(AD_W)) u_ram (
        .clk  (clk),
        .we   (we_q[g]),
        .addr (addr),
        .din  (wd_q),
        .dout (rd_bits[g])
      );
    end
  endgenerate

  assign ab_bit   = ab_bit_q;
  assign ab_word  = ab_word_q;
  assign mr_bit   = mr_bit_q;
  assign mr_word  = mr_word_q;
  assign rd_phase = rd_q;
  assign wr_win   = win_q;
  assign acc_we   = we_q[REG_ACC];
  assign mul_we   = we_q[REG_MUL];
  assign prd_we   = we_q[REG_PRD];
  assign acc_rd   = rd_bits[REG_ACC];
  assign mul_rd   = rd_bits[REG_MUL];
  assign prd_rd   = rd_bits[REG_PRD];

  // ---------------- assertions ----------------
  logic [WA_W-1:0] mr_word_up;
  assign mr_word_up = (mr_word_q == WORD_LAST) ? '0 : mr_word_q + 1'b1;

  // R2
  read_after_win_chk: assert property (@(posedge clk) disable iff (rst)
    win_q |=> rd_q);

  // R2
  win_rd_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(win_q && rd_q));

  // R8
  strobe_in_win_chk: assert property (@(posedge clk) disable iff (rst)
    (|we_q) |-> win_q);

  // R8
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_q));

  // R3
  addr_match_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_q |-> (ab_bit_q == mr_bit_q && ab_word_q == mr_word_q));

  // R5
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && (ab_bit_q != mr_bit_q || ab_word_q != mr_word_q)) |->
      ((ab_bit_q == '0) ? (mr_bit_q == BIT_TOP && ab_word_q == mr_word_up)
                        : (ab_bit_q == mr_bit_q + 1'b1 && ab_word_q == mr_word_q)));

endmodule

// File: tb/rsh_addr_gen_tb.sv
module rsh_addr_gen_tb;
  import rsh_pkg::*;

  localparam int BITS  = 18;
  localparam int WORDS = 4;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] bit_no;
  logic [1:0] word_addr;
  logic       rsh_en, msw, wr_data;
  logic [1:0] wsel;
  logic [4:0] ab_bit, mr_bit;
  logic [1:0] ab_word, mr_word;
  logic       rd_phase, wr_win, acc_we, mul_we, prd_we, acc_rd, mul_rd, prd_rd;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  rsh_addr_gen u_dut (
    .clk(clk), .rst(rst), .bit_no(bit_no), .word_addr(word_addr),
    .rsh_en(rsh_en), .msw(msw), .wsel(wsel), .wr_data(wr_data),
    .ab_bit(ab_bit), .ab_word(ab_word), .mr_bit(mr_bit), .mr_word(mr_word),
    .rd_phase(rd_phase), .wr_win(wr_win), .acc_we(acc_we), .mul_we(mul_we),
    .prd_we(prd_we), .acc_rd(acc_rd), .mul_rd(mul_rd), .prd_rd(prd_rd)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync_win();
    do @(negedge clk); while (!wr_win);
  endtask

  // One bit time; entered and left on the negedge inside the write tick
  task automatic run_bit(input int b, input int w, input logic r, input logic m,
                         input logic [1:0] ws, input logic use_rd, input logic dval,
                         input int ridx, output logic got);
    int    eb, ew;
    string tag;
    bit_no = 5'(b); word_addr = 2'(w); rsh_en = r; msw = m; wsel = WS_NONE;
    eb = b; ew = w; tag = "R3";
    if (r) begin
      if (b == BITS - 1 && m) tag = "R6";
      else if (b == BITS - 1) begin tag = "R5"; eb = 0; ew = (w + 1) % WORDS; end
      else begin tag = "R4"; eb = b + 1; end
    end
    @(negedge clk);  // read tick 0
    check({tag, " ab_bit"}, ab_bit, eb);
    check({tag, " ab_word"}, ab_word, ew);
    check("R7 mr_bit", mr_bit, b);
    check("R7 mr_word", mr_word, w);
    check("R2 rd_phase high", rd_phase, 1);
    check("R8 no strobe in read half", {acc_we, mul_we, prd_we}, 0);
    @(negedge clk);  // read tick 1: data of address seen in tick 0
    got = (ridx == REG_ACC) ? acc_rd : (ridx == REG_MUL) ? mul_rd : prd_rd;
    @(negedge clk);  // tick 2
    check("R3 ab_bit outside read half", ab_bit, b);
    check("R3 ab_word outside read half", ab_word, w);
    check("R2 rd_phase low", rd_phase, 0);
    wr_data = use_rd ? got : dval;
    wsel    = ws;
    @(negedge clk);  // write tick
    check("R2 wr_win", wr_win, 1);
    check("R8 acc_we", acc_we, ws == WS_ACC);
    check("R8 mul_we", mul_we, ws == WS_MUL);
    check("R8 prd_we", prd_we, ws == WS_PRD);
    wsel = WS_NONE;
  endtask

  task automatic write_word(input logic [1:0] ws, input int w, input logic [17:0] v);
    logic g;
    for (int b = 0; b < BITS; b++) run_bit(b, w, 1'b0, 1'b0, ws, 1'b0, v[b], 0, g);
  endtask

  task automatic read_word(input int ridx, input int w, output logic [17:0] v);
    logic g;
    for (int b = 0; b < BITS; b++) begin
      run_bit(b, w, 1'b0, 1'b0, WS_NONE, 1'b0, 1'b0, ridx, g);
      v[b] = g;
    end
  endtask

  task automatic shift_pair(input logic [1:0] ws, input int ridx, input int lo_w);
    logic g;
    for (int b = 0; b < BITS; b++) run_bit(b, lo_w, 1'b1, 1'b0, ws, 1'b1, 1'b0, ridx, g);
    for (int b = 0; b < BITS; b++)
      run_bit(b, (lo_w + 1) % WORDS, 1'b1, 1'b1, ws, 1'b1, 1'b0, ridx, g);
  endtask

  task automatic test_reset();
    rst = 1'b1; bit_no = 5'd9; word_addr = 2'd3; rsh_en = 1'b1; msw = 1'b0;
    wsel = WS_ACC; wr_data = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 rd_phase", rd_phase, 0);
    check("R1 wr_win", wr_win, 0);
    check("R1 strobes", {acc_we, mul_we, prd_we}, 0);
    check("R1 ab", {ab_word, ab_bit}, 0);
    check("R1 mr", {mr_word, mr_bit}, 0);
    wsel = WS_NONE; rsh_en = 1'b0;
    rst = 1'b0;
  endtask

  task automatic test_phases();
    sync_win();
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      check("R2 rd_phase pattern", rd_phase, (p % 4) < 2);
      check("R2 wr_win pattern", wr_win, (p % 4) == 3);
    end
  endtask

  task automatic test_store();
    logic [17:0] v;
    write_word(WS_ACC, 0, 18'h2D1E3);
    write_word(WS_MUL, 1, 18'h15A0F);
    write_word(WS_PRD, 3, 18'h3C0C5);
    read_word(REG_ACC, 0, v); check("R9 acc word 0", v, 18'h2D1E3);
    read_word(REG_MUL, 1, v); check("R9 mul word 1", v, 18'h15A0F);
    read_word(REG_PRD, 3, v); check("R9 prd word 3", v, 18'h3C0C5);
    read_word(REG_ACC, 1, v); check("R9 acc untouched by other targets", v, 18'h00000);
  endtask

  task automatic test_shift(input logic [1:0] ws, input int ridx, input int lo_w,
                            input logic [35:0] val);
    logic [17:0] lo, hi;
    logic [35:0] expv;
    write_word(ws, lo_w, val[17:0]);
    write_word(ws, (lo_w + 1) % WORDS, val[35:18]);
    shift_pair(ws, ridx, lo_w);
    expv = 36'($signed(val) >>> 1);
    read_word(ridx, lo_w, lo);
    read_word(ridx, (lo_w + 1) % WORDS, hi);
    check("R10 shifted low word", lo, expv[17:0]);
    check("R10 shifted high word", hi, expv[35:18]);
  endtask

  task automatic test_mul_fixed();
    logic [17:0] v;
    logic g;
    write_word(WS_MUL, 2, 18'h2B3C5);
    for (int b = 0; b < BITS; b++) run_bit(b, 2, 1'b1, 1'b1, WS_MUL, 1'b1, 1'b0, REG_MUL, g);
    read_word(REG_MUL, 2, v);
    check("R7 multiplier unchanged by shift", v, 18'h2B3C5);
  endtask

  initial begin
    test_reset();
    test_phases();
    test_store();
    test_shift(WS_ACC, REG_ACC, 1, 36'h9A5C31E7B);  // negative, words 1 and 2
    test_shift(WS_PRD, REG_PRD, 3, 36'h30F0F5A5A);  // positive, wraps word 3 to 0
    test_shift(WS_ACC, REG_ACC, 2, 36'h800000001);  // most negative with low bit set
    test_mul_fixed();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule